// File: doc/BRIEF.md
# Readiness-Partitioned Issue Queue

This block holds decoded instructions until their source operands are available, then hands them on one at a time. It is built as a tag-match array beside a payload store. The entries do not all carry the same matching hardware. One group of slots has no tag comparator. A second group has one comparator. A third group has two comparators. When an instruction is accepted, the number of its operands that are still outstanding decides which group it may enter. Slots are never shifted or compacted. An instruction keeps its slot from the moment it is accepted until it is issued.

A result-tag broadcast marks every matching outstanding operand as available. A slot with nothing left outstanding is eligible, and each cycle the lowest-numbered eligible slot is offered on the issue port. Only a few slots in each group hold the wide immediate field. Instructions that carry an immediate are limited to those slots.

Two ports carry data, and both use valid/ready. On the dispatch port, `disp_ready` is computed from the operand-ready bits and the immediate flag on the port in the same cycle. It does not depend on `disp_valid`. A transfer happens when both are high, and the sender may change its fields freely while ready is low. On the issue port, `iss_valid` stays high until `iss_ready` accepts the instruction or a flush arrives. The offered instruction can be replaced by a lower-numbered one that becomes eligible while the port waits. The full indications and the flush are plain level signals.

Top module: `iqp_issue_queue`

## Requirements
- R1: Slots are numbered so that indices 0..N0-1 have no comparator, the next N1 slots have one comparator and the last N2 slots have two. An instruction with both operands ready needs class 0, one with exactly one operand outstanding needs class 1, and one with both outstanding needs class 2. Dispatch picks the lowest-numbered group at or above the needed class that has a suitable free slot, and the lowest free index within that group.
- R2: An instruction is never placed in a group with fewer comparators than its class needs. When no suitable slot is free at or above its class, it is refused even if poorer groups have room.
- R3: `full_plain[c]` is 1 exactly when no slot is free in group c or any richer group. `full_imm[c]` is 1 exactly when no immediate-capable slot is free in group c or any richer group.
- R4: The first M0, M1 and M2 slots of the three groups are immediate-capable. An instruction with `disp_has_imm`=1 goes only to such a slot. Its immediate comes back unchanged on `iss_imm` with `iss_has_imm`=1.
- R5: `disp_ready` is 1 exactly when flush is low and the full bit that matches the presented class and immediate flag is 0. It ignores `disp_valid`.
- R6: A broadcast marks every matching outstanding operand of the resident instructions as available at the clock edge. An instruction becomes eligible in the cycle after its last operand is marked available. A broadcast in the same cycle as an instruction's dispatch does not affect that instruction.
- R7: The issue port offers the lowest-index eligible instruction with its opcode, both source tags and its immediate. Once `iss_valid` is high, it stays high until the instruction is accepted or a flush arrives.
- R8: A slot whose instruction is accepted at a clock edge becomes free at that edge. The full bits and the dispatch side see that slot as free in the following cycle, and not before.
- R9: While `flush` is high, `disp_ready` and `iss_valid` are 0. After the edge, every slot is empty.
- R10: After reset every slot is empty, all full bits are 0 and `iss_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empties the whole queue at the next edge |
| disp_valid | input | 1 | Dispatch request present |
| disp_ready | output | 1 | A compatible free slot exists for the presented request |
| disp_op | input | OPW | Opaque opcode payload |
| disp_tag0 | input | TW | Tag of the first source operand |
| disp_rdy0 | input | 1 | First source operand already available |
| disp_tag1 | input | TW | Tag of the second source operand |
| disp_rdy1 | input | 1 | Second source operand already available |
| disp_has_imm | input | 1 | Request carries an immediate |
| disp_imm | input | IMMW | Immediate value |
| full_plain | output | 3 | Per-class stall for requests without an immediate |
| full_imm | output | 3 | Per-class stall for requests with an immediate |
| bc_valid | input | 1 | Result-tag broadcast present |
| bc_tag | input | TW | Broadcast result tag |
| iss_valid | output | 1 | An eligible instruction is offered |
| iss_ready | input | 1 | Consumer accepts the offered instruction |
| iss_op | output | OPW | Opcode of the offered instruction |
| iss_tag0 | output | TW | First source tag |
| iss_tag1 | output | TW | Second source tag |
| iss_has_imm | output | 1 | Offered instruction carries an immediate |
| iss_imm | output | IMMW | Immediate of the offered instruction |

## Verification
The hardest case to reach is a class-1 or class-0 instruction sitting in a richer slot, left there by borrowing, and waking up or being chosen ahead of an owner of that group. Placement depends on the occupancy history of every group, and it cannot be seen directly. The bench therefore runs a long pseudo-random stream that mixes dispatch, broadcast from a small tag set, issue back-pressure and occasional flushes, all in the same cycles. An independent slot-level model predicts the full vectors, the ready bit and the exact instruction offered each cycle. Directed runs fill one group completely to show that borrowing works in one direction only. Other directed runs show the immediate-only exhaustion, the one-cycle delay before a freed slot can be reused, and the dispatch-cycle broadcast that must not be seen.

// File: rtl/iqp_pkg.sv
package iqp_pkg;

  typedef enum logic [1:0] {
    NEED_NONE = 2'd0,
    NEED_ONE  = 2'd1,
    NEED_TWO  = 2'd2
  } need_e;

  // Number of comparators an instruction needs, from its operand-ready bits.
  function automatic need_e classify(input logic r0, input logic r1);
    if (r0 && r1)      return NEED_NONE;
    else if (r0 || r1) return NEED_ONE;
    else               return NEED_TWO;
  endfunction

endpackage

// File: rtl/iqp_ffs.sv
// Lowest-index request finder.
module iqp_ffs #(
  parameter int W = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  onehot
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  assign onehot = req & (~req + 1'b1);
endmodule

// File: rtl/iqp_alloc.sv
// Slot chooser for dispatch, plus the class-aware full vectors.
module iqp_alloc #(
  parameter int N0 = 4,
  parameter int N1 = 6,
  parameter int N2 = 6,
  parameter int M0 = 2,
  parameter int M1 = 2,
  parameter int M2 = 2,
  localparam int NE = N0 + N1 + N2
) (
  input  logic [NE-1:0]  free,
  input  iqp_pkg::need_e need,
  input  logic           has_imm,
  output logic           found,
  output logic [NE-1:0]  grant,
  output logic [2:0]     full_plain,
  output logic [2:0]     full_imm
);
  function automatic int grp_of(input int i);
    return (i < N0) ? 0 : ((i < N0 + N1) ? 1 : 2);
  endfunction

  function automatic logic cap_of(input int i);
    int g;
    int ofs;
    int lim;
    g   = grp_of(i);
    ofs = (g == 0) ? i : ((g == 1) ? i - N0 : i - N0 - N1);
    lim = (g == 0) ? M0 : ((g == 1) ? M1 : M2);
    return ofs < lim;
  endfunction

  logic [NE-1:0] grp_m [3];
  logic [NE-1:0] cap_m;
  logic [NE-1:0] base;
  logic [NE-1:0] cand  [3];
  logic [NE-1:0] pick;
  logic [2:0]    have;
  logic [2:0]    av_plain;
  logic [2:0]    av_imm;

  always_comb begin
    for (int g = 0; g < 3; g++) grp_m[g] = '0;
    cap_m = '0;
    for (int i = 0; i < NE; i++) begin
      grp_m[grp_of(i)][i] = 1'b1;
      cap_m[i]            = cap_of(i);
    end
  end

  always_comb begin
    base  = free & (has_imm ? cap_m : {NE{1'b1}});
    pick  = '0;
    found = 1'b0;
    for (int g = 0; g < 3; g++) begin
      cand[g]     = base & grp_m[g];
      have[g]     = |cand[g];
      av_plain[g] = |(free & grp_m[g]);
      av_imm[g]   = |(free & grp_m[g] & cap_m);
    end
    // Walk from the richest group down, so the cheapest compatible one wins.
    for (int g = 2; g >= 0; g--) begin
      if (g >= int'(need) && have[g]) begin
        pick  = cand[g];
        found = 1'b1;
      end
    end
  end

  assign grant = pick & (~pick + 1'b1);

  assign full_plain[2] = ~av_plain[2];
  assign full_plain[1] = ~(av_plain[1] | av_plain[2]);
  assign full_plain[0] = ~(|av_plain);
  assign full_imm[2]   = ~av_imm[2];
  assign full_imm[1]   = ~(av_imm[1] | av_imm[2]);
  assign full_imm[0]   = ~(|av_imm);
endmodule

// File: rtl/iqp_entry.sv
// Occupancy and wakeup state of one slot; NCMP picks the comparator count.
module iqp_entry #(
  parameter int NCMP = 2,
  parameter int TW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          alloc,
  input  logic          leave,
  input  logic [TW-1:0] tag0,
  input  logic          rdy0,
  input  logic [TW-1:0] tag1,
  input  logic          rdy1,
  input  logic          bc_valid,
  input  logic [TW-1:0] bc_tag,
  output logic          valid,
  output logic          eligible
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid <= 1'b0;
    else if (flush) valid <= 1'b0;
    else if (alloc) valid <= 1'b1;
    else if (leave) valid <= 1'b0;
  end

  generate
    if (NCMP == 0) begin : g_c0
      logic unused_ok;
      assign unused_ok = ^{tag0, rdy0, tag1, rdy1, bc_valid, bc_tag};
      assign eligible  = valid;
    end else if (NCMP == 1) begin : g_c1
      logic [TW-1:0] wt;
      logic          wr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wt <= '0;
          wr <= 1'b0;
        end else if (alloc) begin
          wt <= rdy0 ? tag1 : tag0;
          wr <= rdy0 & rdy1;
        end else if (bc_valid && bc_tag == wt) begin
          wr <= 1'b1;
        end
      end
      assign eligible = valid & wr;
    end else begin : g_c2
      logic [TW-1:0] wt0, wt1;
      logic          wr0, wr1;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wt0 <= '0;
          wt1 <= '0;
          wr0 <= 1'b0;
          wr1 <= 1'b0;
        end else if (alloc) begin
          wt0 <= tag0;
          wt1 <= tag1;
          wr0 <= rdy0;
          wr1 <= rdy1;
        end else if (bc_valid) begin
          if (bc_tag == wt0) wr0 <= 1'b1;
          if (bc_tag == wt1) wr1 <= 1'b1;
        end
      end
      assign eligible = valid & wr0 & wr1;
    end
  endgenerate
endmodule

// File: rtl/iqp_issue_queue.sv
module iqp_issue_queue #(
  parameter int N0   = 4,
  parameter int N1   = 6,
  parameter int N2   = 6,
  parameter int M0   = 2,
  parameter int M1   = 2,
  parameter int M2   = 2,
  parameter int TW   = 6,
  parameter int OPW  = 8,
  parameter int IMMW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            disp_valid,
  output logic            disp_ready,
  input  logic [OPW-1:0]  disp_op,
  input  logic [TW-1:0]   disp_tag0,
  input  logic            disp_rdy0,
  input  logic [TW-1:0]   disp_tag1,
  input  logic            disp_rdy1,
  input  logic            disp_has_imm,
  input  logic [IMMW-1:0] disp_imm,
  output logic [2:0]      full_plain,
  output logic [2:0]      full_imm,
  input  logic            bc_valid,
  input  logic [TW-1:0]   bc_tag,
  output logic            iss_valid,
  input  logic            iss_ready,
  output logic [OPW-1:0]  iss_op,
  output logic [TW-1:0]   iss_tag0,
  output logic [TW-1:0]   iss_tag1,
  output logic            iss_has_imm,
  output logic [IMMW-1:0] iss_imm
);
  import iqp_pkg::*;

  localparam int NE = N0 + N1 + N2;
  localparam int IW = (NE > 1) ? $clog2(NE) : 1;

  need_e          need;
  logic [NE-1:0]  valid_v, elig_v, grant, alloc_v, leave_v, sel_oh;
  logic           gnt_found, sel_found, disp_fire, iss_fire;
  logic [IW-1:0]  sel_idx;

  logic [OPW-1:0]  op_rd  [NE];
  logic [TW-1:0]   t0_rd  [NE];
  logic [TW-1:0]   t1_rd  [NE];
  logic            hi_rd  [NE];
  logic [IMMW-1:0] imm_rd [NE];

  assign need = classify(disp_rdy0, disp_rdy1);

  iqp_alloc #(.N0(N0), .N1(N1), .N2(N2), .M0(M0), .M1(M1), .M2(M2)) u_alloc (
    .free       (~valid_v),
    .need       (need),
    .has_imm    (disp_has_imm),
    .found      (gnt_found),
    .grant      (grant),
    .full_plain (full_plain),
    .full_imm   (full_imm)
  );

  assign disp_ready = gnt_found & ~flush;
  assign disp_fire  = disp_valid & disp_ready;
  assign alloc_v    = grant & {NE{disp_fire}};

  iqp_ffs #(.W(NE)) u_select (
    .req    (elig_v),
    .found  (sel_found),
    .idx    (sel_idx),
    .onehot (sel_oh)
  );

  assign iss_valid = sel_found & ~flush;
  assign iss_fire  = iss_valid & iss_ready;
  assign leave_v   = sel_oh & {NE{iss_fire}};

  generate
    for (genvar i = 0; i < NE; i++) begin : g_slot
      localparam int GRP = (i < N0) ? 0 : ((i < N0 + N1) ? 1 : 2);
      localparam int OFS = (GRP == 0) ? i : ((GRP == 1) ? i - N0 : i - N0 - N1);
      localparam int LIM = (GRP == 0) ? M0 : ((GRP == 1) ? M1 : M2);

      iqp_entry #(.NCMP(GRP), .TW(TW)) u_ent (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .alloc    (alloc_v[i]),
        .leave    (leave_v[i]),
        .tag0     (disp_tag0),
        .rdy0     (disp_rdy0),
        .tag1     (disp_tag1),
        .rdy1     (disp_rdy1),
        .bc_valid (bc_valid),
        .bc_tag   (bc_tag),
        .valid    (valid_v[i]),
        .eligible (elig_v[i])
      );

      // Payload store: fields never compared, written once on entry.
      logic [OPW-1:0] op_r;
      logic [TW-1:0]  t0_r, t1_r;
      logic           hi_r;
      always_ff @(posedge clk) begin
        if (alloc_v[i]) begin
          op_r <= disp_op;
          t0_r <= disp_tag0;
          t1_r <= disp_tag1;
          hi_r <= disp_has_imm;
        end
      end
      assign op_rd[i] = op_r;
      assign t0_rd[i] = t0_r;
      assign t1_rd[i] = t1_r;
      assign hi_rd[i] = hi_r;

      if (OFS < LIM) begin : g_imm
        logic [IMMW-1:0] imm_r;
        always_ff @(posedge clk) begin
          if (alloc_v[i]) imm_r <= disp_imm;
        end
        assign imm_rd[i] = imm_r;
      end else begin : g_noimm
        assign imm_rd[i] = '0;
      end
    end
  endgenerate

  assign iss_op      = op_rd[sel_idx];
  assign iss_tag0    = t0_rd[sel_idx];
  assign iss_tag1    = t1_rd[sel_idx];
  assign iss_has_imm = hi_rd[sel_idx];
  assign iss_imm     = imm_rd[sel_idx];
endmodule

// File: rtl/iqp_issue_queue_chk.sv
module iqp_issue_queue_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flush,
  input logic       disp_ready,
  input logic       disp_rdy0,
  input logic       disp_rdy1,
  input logic       disp_has_imm,
  input logic [2:0] full_plain,
  input logic [2:0] full_imm,
  input logic       iss_valid,
  input logic       iss_ready
);
  logic [1:0] cls;
  logic       cls_full;

  assign cls      = (disp_rdy0 && disp_rdy1) ? 2'd0 : ((disp_rdy0 || disp_rdy1) ? 2'd1 : 2'd2);
  assign cls_full = disp_has_imm ? full_imm[cls] : full_plain[cls];

  AST_BORROW_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_plain[0] || full_plain[1]) && (!full_plain[1] || full_plain[2])); // R3

  AST_IMM_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (full_plain & ~full_imm) == 3'b000); // R4

  AST_STALL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    disp_ready == (!flush && !cls_full)); // R5

  AST_ISSUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && !flush) |=> (iss_valid || flush)); // R7

  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!disp_ready && !iss_valid)); // R9

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (full_plain == 3'b000 && !iss_valid)); // R9
endmodule

bind iqp_issue_queue iqp_issue_queue_chk u_chk (.*);

// File: tb/iqp_issue_queue_tb.sv
module iqp_issue_queue_tb;
  localparam int N0 = 4, N1 = 6, N2 = 6, M0 = 2, M1 = 2, M2 = 2;
  localparam int NE = N0 + N1 + N2;

  logic        clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic        disp_valid = 1'b0, disp_ready;
  logic [7:0]  disp_op = '0;
  logic [5:0]  disp_tag0 = '0, disp_tag1 = '0;
  logic        disp_rdy0 = 1'b0, disp_rdy1 = 1'b0, disp_has_imm = 1'b0;
  logic [31:0] disp_imm = '0;
  logic [2:0]  full_plain, full_imm;
  logic        bc_valid = 1'b0;
  logic [5:0]  bc_tag = '0;
  logic        iss_valid, iss_ready = 1'b0;
  logic [7:0]  iss_op;
  logic [5:0]  iss_tag0, iss_tag1;
  logic        iss_has_imm;
  logic [31:0] iss_imm;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  bit          mv [NE];
  bit          mr0 [NE], mr1 [NE], mhi [NE];
  logic [5:0]  mt0 [NE], mt1 [NE];
  logic [7:0]  mop [NE];
  logic [31:0] mimm [NE];

  always #10 clk = ~clk;

  iqp_issue_queue u_dut (.*);

  function automatic int grp_of(input int i);
    return (i < N0) ? 0 : ((i < N0 + N1) ? 1 : 2);
  endfunction

  function automatic bit cap_of(input int i);
    int g, o;
    g = grp_of(i);
    o = (g == 0) ? i : ((g == 1) ? i - N0 : i - N0 - N1);
    return o < ((g == 0) ? M0 : ((g == 1) ? M1 : M2));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int count_valid();
    int n = 0;
    for (int i = 0; i < NE; i++) if (mv[i]) n++;
    return n;
  endfunction

  // One clock cycle: drive at the falling edge, check the combinational
  // outputs against the model, then advance the model at the rising edge.
  task automatic cyc(input bit dv, input logic [7:0] op,
                     input logic [5:0] t0, input bit r0,
                     input logic [5:0] t1, input bit r1,
                     input bit hi, input logic [31:0] imm,
                     input bit bv, input logic [5:0] bt,
                     input bit ir, input bit fl);
    bit [2:0] av_p, av_i;
    logic [2:0] ef_p, ef_i;
    int need, gnt, sel;
    bit edr, eiv;
    @(negedge clk);
    disp_valid = dv; disp_op = op; disp_tag0 = t0; disp_rdy0 = r0;
    disp_tag1 = t1; disp_rdy1 = r1; disp_has_imm = hi; disp_imm = imm;
    bc_valid = bv; bc_tag = bt; iss_ready = ir; flush = fl;
    #1;
    av_p = '0; av_i = '0;
    for (int i = 0; i < NE; i++) if (!mv[i]) begin
      av_p[grp_of(i)] = 1'b1;
      if (cap_of(i)) av_i[grp_of(i)] = 1'b1;
    end
    ef_p = {~av_p[2], ~(av_p[2] | av_p[1]), ~(|av_p)};
    ef_i = {~av_i[2], ~(av_i[2] | av_i[1]), ~(|av_i)};
    need = (r0 && r1) ? 0 : ((r0 || r1) ? 1 : 2);
    gnt = -1;
    for (int g = 0; g < 3 && gnt < 0; g++) if (g >= need)
      for (int i = 0; i < NE && gnt < 0; i++)
        if (grp_of(i) == g && !mv[i] && (!hi || cap_of(i))) gnt = i;
    sel = -1;
    for (int i = NE - 1; i >= 0; i--) if (mv[i] && mr0[i] && mr1[i]) sel = i;
    edr = !fl && gnt >= 0;
    eiv = !fl && sel >= 0;
    chk(full_plain == ef_p, "R3", "full_plain", full_plain, ef_p);
    chk(full_imm == ef_i, "R3", "full_imm", full_imm, ef_i);
    chk(disp_ready == edr, "R5", "disp_ready", disp_ready, edr);
    chk(iss_valid == eiv, "R7", "iss_valid", iss_valid, eiv);
    if (eiv && iss_valid) begin
      chk(iss_op == mop[sel], "R1", "iss_op (placement/order)", iss_op, mop[sel]);
      chk(iss_tag0 == mt0[sel] && iss_tag1 == mt1[sel], "R7", "iss tags",
          {iss_tag0, iss_tag1}, {mt0[sel], mt1[sel]});
      chk(iss_has_imm == mhi[sel], "R4", "iss_has_imm", iss_has_imm, mhi[sel]);
      if (mhi[sel]) chk(iss_imm == mimm[sel], "R4", "iss_imm", iss_imm, mimm[sel]);
    end
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < NE; i++) mv[i] = 1'b0;
    end else begin
      if (bv) for (int i = 0; i < NE; i++) if (mv[i]) begin
        if (mt0[i] == bt) mr0[i] = 1'b1;
        if (mt1[i] == bt) mr1[i] = 1'b1;
      end
      if (eiv && ir) mv[sel] = 1'b0;
      if (dv && edr) begin
        mv[gnt] = 1'b1; mr0[gnt] = r0; mr1[gnt] = r1; mt0[gnt] = t0; mt1[gnt] = t1;
        mop[gnt] = op; mhi[gnt] = hi; mimm[gnt] = imm;
      end
    end
  endtask

  task automatic idle();
    cyc(0, 8'd0, 6'd0, 1, 6'd0, 1, 0, 32'd0, 0, 6'd0, 0, 0);
  endtask

  task automatic peek(input bit r0, input bit r1, input bit hi);
    @(negedge clk);
    disp_valid = 0; iss_ready = 0; bc_valid = 0; flush = 0;
    disp_rdy0 = r0; disp_rdy1 = r1; disp_has_imm = hi;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit [31:0] lf;
    for (int i = 0; i < NE; i++) mv[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    peek(0, 0, 0);
    chk(iss_valid == 1'b0, "R10", "iss_valid after reset", iss_valid, 0);
    chk(full_plain == 3'b000 && full_imm == 3'b000, "R10", "full after reset",
        {full_plain, full_imm}, 0);
    chk(disp_ready == 1'b1, "R10", "disp_ready after reset", disp_ready, 1);

    // R2: six class-2 instructions fill the two-comparator group.
    for (int k = 0; k < N2; k++)
      cyc(1, 8'(10 + k), 6'(40 + k), 0, 6'(50 + k), 0, 0, 32'd0, 0, 6'd0, 0, 0);
    peek(0, 0, 0);
    chk(disp_ready == 1'b0, "R2", "class-2 refused with poorer groups free", disp_ready, 0);
    chk(full_plain == 3'b100, "R2", "full_plain after group 2 filled", full_plain, 3'b100);
    peek(1, 0, 0);
    chk(disp_ready == 1'b1, "R2", "class-1 still accepted", disp_ready, 1);

    // R6: a class-1 instruction waiting on tag 40 arrives with a broadcast of 40.
    cyc(1, 8'd99, 6'd40, 0, 6'd1, 1, 0, 32'd0, 1, 6'd40, 0, 0);
    cyc(0, 8'd0, 6'd0, 1, 6'd0, 1, 0, 32'd0, 1, 6'd50, 0, 0);
    peek(1, 1, 0);
    chk(iss_valid && iss_op == 8'd10, "R6", "resident entry woken by both tags",
        iss_op, 10);
    cyc(0, 8'd0, 6'd0, 1, 6'd0, 1, 0, 32'd0, 1, 6'd40, 0, 0);
    peek(1, 1, 0);
    chk(iss_valid && iss_op == 8'd99, "R6", "dispatch-cycle broadcast ignored, later one seen",
        iss_op, 99);

    // R8: fill every slot, then release one.
    while (count_valid() < NE)
      cyc(1, 8'(120 + count_valid()), 6'd2, 1, 6'd3, 1, 0, 32'd0, 0, 6'd0, 0, 0);
    peek(1, 1, 0);
    chk(full_plain[0] == 1'b1 && disp_ready == 1'b0, "R8", "queue full",
        full_plain[0], 1);
    cyc(0, 8'd0, 6'd0, 1, 6'd0, 1, 0, 32'd0, 0, 6'd0, 1, 0);
    peek(1, 1, 0);
    chk(full_plain[0] == 1'b0 && disp_ready == 1'b1, "R8", "freed slot visible next cycle",
        full_plain[0], 0);

    // R9: flush empties everything.
    cyc(1, 8'd7, 6'd0, 1, 6'd0, 1, 0, 32'd0, 0, 6'd0, 1, 1);
    peek(0, 0, 0);
    chk(iss_valid == 1'b0 && full_plain == 3'b000, "R9", "queue empty after flush",
        {iss_valid, full_plain}, 0);

    // R4: only six immediate-capable slots exist.
    for (int k = 0; k < 6; k++)
      cyc(1, 8'(200 + k), 6'd4, 1, 6'd5, 1, 1, 32'hA5A5_0000 + 32'(k), 0, 6'd0, 0, 0);
    peek(1, 1, 1);
    chk(disp_ready == 1'b0 && full_imm == 3'b111, "R4", "immediate slots exhausted",
        full_imm, 3'b111);
    peek(1, 1, 0);
    chk(disp_ready == 1'b1 && full_plain == 3'b000, "R4", "plain slots still free",
        full_plain, 0);
    for (int k = 0; k < 6; k++) cyc(0, 8'd0, 6'd0, 1, 6'd0, 1, 0, 32'd0, 0, 6'd0, 1, 0);

    // Mixed pseudo-random traffic.
    lf = 32'h1ACE_B00C;
    for (int n = 0; n < 4000; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      cyc(lf[0] | lf[1], 8'(n), {3'b0, lf[10:8]}, lf[11], {3'b0, lf[14:12]}, lf[15],
          lf[17:16] == 2'b00, lf ^ 32'(n), lf[3] | lf[4], {3'b0, lf[7:5]},
          lf[2], lf[23:18] == 6'd0);
    end
    idle();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule